// File: doc/BRIEF.md
# Write Permission and Status Register Unit

This unit sits beside the command decoder of a small serial non-volatile memory. It holds the status byte that the host reads back: two block-protect bits, the write-enable latch and a busy flag. It also answers one question for every write the decoder wants to start: may this array write or status write go ahead? The answer depends on three things. The first is the hardware protect pin. The second is the write-enable latch. The third is the address range that the block-protect bits fence off. The array storage and the serial shifter are outside this unit.

The decoder sends single-cycle strobes to the unit at the moment the chip-select is released. These strobes are: a latch-set request qualified by a flag meaning "exactly one instruction byte was clocked", a latch-clear request, a status-write request carrying the new status byte, and an array-write request carrying the target address. The internal write sequencer supplies a busy level and a one-cycle done pulse, issued in the last busy cycle. The block-protect bits come out of reset at a parameter value, which stands in for their non-volatile contents.

Top module: `wprot_status_unit`

## Requirements
- R1: While reset is held, and directly after it, `status_byte` reads {4'b0000, BP_RESET, 1'b0, wr_busy}.
- R2: The `status_byte` layout is: bits 7..4 always 0, bit 3 the upper protect bit, bit 2 the lower protect bit, bit 1 the write-enable latch, bit 0 equal to `wr_busy`.
- R3: A `set_wel` strobe with `frame_exact`=1, `wp_n`=1 and `wr_busy`=0 sets the latch on the next edge. With `frame_exact`=0 the latch is left unchanged.
- R4: The latch is cleared on the next edge in three cases: whenever `wp_n` is 0, whenever `wr_done` is 1, or when a `clr_wel` strobe arrives while not busy. A clear dominates a same-cycle set.
- R5: The protected region depends on the protect bits. 00: nothing. 01: addresses whose two top bits are 11 (0x180-0x1FF at 9 bits). 10: addresses whose top bit is 1 (0x100-0x1FF). 11: every address.
- R6: `permit` with `req_array` is 1 only when `wp_n`=1, the latch is 1, `wr_busy`=0 and `req_addr` lies outside the protected region.
- R7: `permit` with `req_status` is 1 only when `wp_n`=1, the latch is 1 and `wr_busy`=0. A permitted status write loads bits 3..2 of `status_data` into the protect bits and ignores all other bits. A refused one leaves the protect bits unchanged.
- R8: Latch set and clear work for every protect-bit setting, including 11.
- R9: Dropping `wp_n` while `wr_busy`=1 clears the latch but leaves bit 0 of `status_byte` at 1 until `wr_busy` falls. The write already underway is not aborted.
- R10: While `wr_busy`=1, set and clear strobes have no effect on the latch, and `permit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Hardware protect pin, low refuses all writes |
| set_wel | input | 1 | Latch-set strobe from decoder |
| frame_exact | input | 1 | Frame held exactly one instruction byte |
| clr_wel | input | 1 | Latch-clear strobe from decoder |
| req_status | input | 1 | Status-write request strobe |
| status_data | input | 8 | Byte received with a status write |
| req_array | input | 1 | Array-write request strobe |
| req_addr | input | ADDR_W | Target address of the array write |
| wr_busy | input | 1 | Internal write cycle in progress |
| wr_done | input | 1 | Last cycle of an internal write |
| status_byte | output | 8 | Status byte for read-back |
| permit | output | 1 | Current request may proceed |

## Verification
The case that matters most is when the protect pin falls in the same cycle as a latch-set strobe. The clear must win, so the latch reads 0 on the next edge. Directed steps create this coincidence. Random stimulus also creates it, because the pin is dropped at random while strobes fire. A second overlap is the protect pin falling while a write is busy. The bench expects the latch to clear, the busy bit to stay at 1, and every request during that window to be refused. A cycle model in the bench predicts both `permit` and the registered status byte.

// File: rtl/wprot_status_unit.sv
module wprot_status_unit #(
  parameter int          ADDR_W   = 9,
  parameter logic [1:0]  BP_RESET = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              set_wel,
  input  logic              frame_exact,
  input  logic              clr_wel,
  input  logic              req_status,
  input  logic [7:0]        status_data,
  input  logic              req_array,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              wr_busy,
  input  logic              wr_done,
  output logic [7:0]        status_byte,
  output logic              permit
);

  logic [1:0] bp;
  logic       wel;
  logic       in_fence;
  logic       gate_ok;
  logic       status_go;

  always_comb begin
    case (bp)
      2'b00:   in_fence = 1'b0;
      2'b01:   in_fence = &req_addr[ADDR_W-1 -: 2];
      2'b10:   in_fence = req_addr[ADDR_W-1];
      default: in_fence = 1'b1;
    endcase
  end

  assign gate_ok   = wp_n & wel & ~wr_busy;
  assign status_go = req_status & gate_ok;
  assign permit    = status_go | (req_array & gate_ok & ~in_fence);
  assign status_byte = {4'b0000, bp, wel, wr_busy};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp  <= BP_RESET;
      wel <= 1'b0;
    end else begin
      if (status_go) bp <= status_data[3:2];
      if (!wp_n || wr_done || (clr_wel && !wr_busy))
        wel <= 1'b0;
      else if (set_wel && frame_exact && !wr_busy)
        wel <= 1'b1;
    end
  end

  assert_wp_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> !status_byte[1]);
  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !status_byte[1]);
  assert_set_works_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wel && frame_exact && wp_n && !wr_busy && !wr_done && !clr_wel) |=> status_byte[1]);
  assert_busy_refuses_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !permit);
  assert_permit_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> (wp_n && status_byte[1]));
  assert_bp_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_status && permit) |=> $stable(status_byte[3:2]));
  assert_high_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[7:4] == 4'b0000);

endmodule

// File: tb/wprot_status_unit_bench.sv
module wprot_status_unit_bench;
  localparam int         AW  = 9;
  localparam logic [1:0] BPR = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1, set_wel = 1'b0, frame_exact = 1'b0, clr_wel = 1'b0;
  logic req_status = 1'b0, req_array = 1'b0, wr_busy = 1'b0, wr_done = 1'b0;
  logic [7:0] status_data = 8'h00;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] status_byte;
  logic permit;

  int checks = 0, failures = 0;
  logic [1:0] m_bp;
  logic m_wel;

  always #2 clk = ~clk;

  wprot_status_unit #(.ADDR_W(AW), .BP_RESET(BPR)) u_wprot_status_unit (
    .clk, .rst_n, .wp_n, .set_wel, .frame_exact, .clr_wel, .req_status,
    .status_data, .req_array, .req_addr, .wr_busy, .wr_done, .status_byte, .permit);

  function automatic logic fenced(input logic [1:0] b, input logic [AW-1:0] a);
    case (b)
      2'b00: return 1'b0;
      2'b01: return a >= 9'h180;
      2'b10: return a >= 9'h100;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic wp, input logic st, input logic ex,
                      input logic cl, input logic rs, input logic [7:0] sd,
                      input logic ra, input logic [AW-1:0] ad, input logic bz, input logic dn);
    logic ok, ep;
    @(negedge clk);
    wp_n = wp; set_wel = st; frame_exact = ex; clr_wel = cl; req_status = rs;
    status_data = sd; req_array = ra; req_addr = ad; wr_busy = bz; wr_done = dn;
    #1;
    ok = wp & m_wel & ~bz;
    ep = (rs & ok) | (ra & ok & ~fenced(m_bp, ad));
    chk(permit == ep, {tag, " permit"}, {7'd0, permit}, {7'd0, ep});
    if (rs & ok) m_bp = sd[3:2];
    if (!wp || dn || (cl && !bz)) m_wel = 1'b0;
    else if (st && ex && !bz) m_wel = 1'b1;
    @(posedge clk); #1;
    chk(status_byte == {4'b0, m_bp, m_wel, bz}, {tag, " status"}, status_byte, {4'b0, m_bp, m_wel, bz});
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_bp = BPR; m_wel = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(status_byte == {4'b0, BPR, 2'b00}, "R1 in reset", status_byte, {4'b0, BPR, 2'b00});
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(status_byte == {4'b0, BPR, 2'b00}, "R1 after reset", status_byte, {4'b0, BPR, 2'b00});

    step("R3 inexact frame", 1,1,0,0,0,8'h00,0,9'h000,0,0);
    step("R3 exact frame",   1,1,1,0,0,8'h00,0,9'h000,0,0);
    step("R5 R6 fenced 0x100", 1,0,0,0,0,8'h00,1,9'h100,0,0);
    step("R5 R6 open 0x0FF",   1,0,0,0,0,8'h00,1,9'h0FF,0,0);
    step("R7 R2 load 01",  1,0,0,0,1,8'hF7,0,9'h000,0,0);
    step("R5 open 0x17F",  1,0,0,0,0,8'h00,1,9'h17F,0,0);
    step("R5 fenced 0x180",1,0,0,0,0,8'h00,1,9'h180,0,0);
    step("R7 load 11",     1,0,0,0,1,8'h0C,0,9'h000,0,0);
    step("R5 all fenced",  1,0,0,0,0,8'h00,1,9'h000,0,0);
    step("R8 clear at 11", 1,0,0,1,0,8'h00,0,9'h000,0,0);
    step("R7 refused no wel", 1,0,0,0,1,8'h00,0,9'h000,0,0);
    step("R8 set at 11",   1,1,1,0,0,8'h00,0,9'h000,0,0);
    step("R4 clear beats set", 1,1,1,1,0,8'h00,0,9'h000,0,0);
    step("R3 set again",   1,1,1,0,0,8'h00,0,9'h000,0,0);
    step("R4 wp drop with set", 0,1,1,0,0,8'h00,0,9'h000,0,0);
    step("R7 wp low refuse", 0,0,0,0,1,8'h00,0,9'h000,0,0);
    step("R3 set",         1,1,1,0,0,8'h00,0,9'h000,0,0);
    step("R7 clear bp",    1,0,0,0,1,8'h00,0,9'h000,0,0);
    step("R10 busy refuse",1,0,0,1,1,8'h0C,1,9'h000,1,0);
    step("R9 wp drop busy",0,0,0,0,0,8'h00,0,9'h000,1,0);
    step("R10 set in busy",1,1,1,0,0,8'h00,0,9'h000,1,0);
    step("R9 busy ends",   1,0,0,0,0,8'h00,0,9'h000,1,1);
    step("R3 set",         1,1,1,0,0,8'h00,0,9'h000,0,0);
    step("R4 done clears", 1,0,0,0,0,8'h00,0,9'h000,1,1);

    for (int i = 0; i < 3000; i++) begin
      logic bz;
      bz = ($urandom % 5) == 0;
      step("R6 R7 R4 random", ($urandom % 8) != 0, $urandom, ($urandom % 4) != 0,
           ($urandom % 6) == 0, ($urandom % 4) == 0, 8'($urandom), $urandom,
           AW'($urandom), bz, bz & (($urandom % 2) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule